// File: doc/BRIEF.md
# PLL Configuration Sequencer

This block turns a requested PLL output frequency, given in hertz, into a complete set of PLL register values, and then brings the PLL up in a safe order. A single start pulse begins the work. The block first range-checks the request. It then decides whether the post-divide-by-two stage is needed, so that the VCO stays at or above its minimum frequency.

The integer feedback multiplier is computed with a multi-cycle shift-subtract divider against a 33,333,000 Hz reference. Loop-filter and lock settings are then read from a built-in range table. Everything is written through a single-cycle register-write port, in a fixed sequence: multiplier, configuration, bypass on, PLL reset pulse, wait for lock, bypass off.

The results stay on status outputs until the next accepted start:
- the multiplier, the divide-by-two flag and the loop fields;
- the nominal output frequency, which is the multiplier times the reference.

A lock that does not arrive within a parameterised number of cycles ends the run with an error, and the PLL is left in bypass.

Top module: `pll_cfg_seq`

## Requirements
- R1: A start with `target_hz` below 750,000,000 or above 1,600,000,000 produces a one-cycle `err` pulse in the next cycle. It writes nothing on the register port and clears the status outputs to zero.
- R2: `st_div2` is 1 exactly when the accepted target is below 1,500,000,000.
- R3: `st_fdiv` equals floor(target × (1 + div2) / 33,333,000), saturated at 125.
- R4: The loop fields come from the first table row whose upper multiplier bound is at least `st_fdiv`, and the fields follow this table:

  | Multiplier | Charge pump | Resistor | Lock count |
  |---|---|---|---|
  | ≤26 | 3 | 10 | 1000 |
  | 27–30 | 4 | 6 | 1000 |
  | 31–32 | 6 | 1 | 1000 |
  | 33 | 4 | 10 | 1000 |
  | 34–38 | 5 | 6 | 1000, except 975 at 38 |
  | 39–50 | 3 | 12 | falls from 950 at 39 to 750 at 50 |
  | 51–60 | 3 | 2 | falls from 725 at 51 to 625 at 58–60 |
  | 61–82 | 3 | 2 | 600 |
  | 83–102 | 4 | 2 | 600 |
  | 103–106 | 5 | 2 | 600 |
  | 107–125 | 3 | 4 | 600 |

  The filter band is always 3 and the lock delay is always 63.
- R5: Write encoding:
  - `wr_sel` = 0 selects the control word, and `wr_sel` = 1 selects the configuration word.
  - The control word carries the multiplier in bits 6:0, div2 in bit 7, bypass in bit 8 and PLL reset in bit 9.
  - The configuration word carries the charge pump in bits 3:0, the resistor in bits 7:4, the filter band in bits 9:8, the lock delay in bits 15:10 and the lock count in bits 25:16.
  - All other bits are zero.
- R6: An in-range start produces this exact write order:
  1. control word with bypass 0 and reset 0;
  2. configuration word;
  3. control word with bypass 1;
  4. control word with bypass 1 and reset 1;
  5. control word with bypass 1 and reset 0;
  6. after lock, control word with bypass 0 and reset 0.
- R7: The strobe that clears the PLL reset comes at least `RST_CYC` cycles after the strobe that sets it.
- R8: If `pll_locked` is not seen within `LOCK_TO_CYC` cycles of the reset release, the block pulses `err`, returns to idle and does not write the bypass release.
- R9: `done` is a one-cycle pulse in the cycle right after the bypass-release strobe, and `done` and `err` are never high together.
- R10: A start that arrives while `busy` is high is ignored: the run in progress finishes with its own values.
- R11: `freq_hz` equals `st_fdiv` × 33,333,000, and all status outputs hold their values after a run until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse; ignored while busy |
| target_hz | input | FREQ_W | Requested PLL output frequency in Hz |
| pll_locked | input | 1 | Lock indication from the PLL |
| wr_en | output | 1 | Single-cycle register write strobe |
| wr_sel | output | 1 | 0 = control word, 1 = configuration word |
| wr_data | output | DATA_W | Register write data |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse after bypass release |
| err | output | 1 | One-cycle pulse on range reject or lock timeout |
| st_fdiv | output | 7 | Computed feedback multiplier |
| st_div2 | output | 1 | Post divide-by-two selected |
| st_cp | output | 4 | Charge-pump setting |
| st_res | output | 4 | Loop resistor setting |
| st_lfhf | output | 2 | Filter band setting |
| st_lock_dly | output | 6 | Lock delay setting |
| st_lock_cnt | output | 10 | Lock count setting |
| freq_hz | output | FREQ_W+7 | Nominal output frequency, multiplier × reference |

## Verification
The hardest situation to reach from the ports is the lock timeout, together with the recovery after it. The bench's PLL model watches the reset strobes on the write port. For one run it withholds lock, which drives the sequencer into the lock-wait expiry with bypass still asserted. A following normal run then shows that the block recovers cleanly. Targets just inside and just outside both range limits, and either side of the divide-by-two threshold, exercise the truncation and the table boundaries. A second start issued in the middle of a run checks that a start during a busy run is ignored.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

    localparam int unsigned MUL_W        = 7;
    localparam logic [MUL_W-1:0] MUL_CAP = 7'd125;
    localparam int unsigned CTRL_BYP_BIT = 8;
    localparam int unsigned CTRL_RST_BIT = 9;
    localparam logic SEL_CTRL = 1'b0;
    localparam logic SEL_CFG  = 1'b1;

    typedef enum logic [3:0] {
        S_IDLE,
        S_DIVIDE,
        S_WR_MUL,
        S_WR_CFG,
        S_WR_BYP,
        S_WR_RST_ON,
        S_RST_HOLD,
        S_WR_RST_OFF,
        S_LOCK_WAIT,
        S_WR_REL,
        S_FIN
    } seq_state_e;

    // Packed so that the charge pump ends up in the least significant bits.
    typedef struct packed {
        logic [9:0] lock_cnt;
        logic [5:0] lock_dly;
        logic [1:0] lfhf;
        logic [3:0] res;
        logic [3:0] cp;
    } loop_cfg_t;

    typedef struct packed {
        logic             rst;
        logic             byp;
        logic             div2;
        logic [MUL_W-1:0] mul;
    } ctrl_word_t;

    function automatic ctrl_word_t make_ctrl(input logic [MUL_W-1:0] mul,
                                             input logic div2,
                                             input logic byp,
                                             input logic rst);
        ctrl_word_t w;
        w.mul  = mul;
        w.div2 = div2;
        w.byp  = byp;
        w.rst  = rst;
        return w;
    endfunction

    // Lock count for the stepped region of the table.
    function automatic logic [9:0] stepped_count(input logic [MUL_W-1:0] m);
        logic [9:0] c;
        case (m)
            7'd38:                c = 10'd975;
            7'd39:                c = 10'd950;
            7'd40:                c = 10'd925;
            7'd41:                c = 10'd900;
            7'd42:                c = 10'd875;
            7'd43, 7'd44:         c = 10'd850;
            7'd45:                c = 10'd825;
            7'd46:                c = 10'd800;
            7'd47, 7'd48:         c = 10'd775;
            7'd49, 7'd50:         c = 10'd750;
            7'd51:                c = 10'd725;
            7'd52, 7'd53:         c = 10'd700;
            7'd54, 7'd55:         c = 10'd675;
            7'd56, 7'd57:         c = 10'd650;
            default:              c = 10'd625;
        endcase
        return c;
    endfunction

    function automatic loop_cfg_t lookup_loop(input logic [MUL_W-1:0] m);
        loop_cfg_t r;
        r.lfhf     = 2'd3;
        r.lock_dly = 6'd63;
        r.lock_cnt = (m <= 7'd37) ? 10'd1000 :
                     (m <= 7'd60) ? stepped_count(m) : 10'd600;
        if (m <= 7'd26)       begin r.cp = 4'd3; r.res = 4'd10; end
        else if (m <= 7'd30)  begin r.cp = 4'd4; r.res = 4'd6;  end
        else if (m <= 7'd32)  begin r.cp = 4'd6; r.res = 4'd1;  end
        else if (m == 7'd33)  begin r.cp = 4'd4; r.res = 4'd10; end
        else if (m <= 7'd38)  begin r.cp = 4'd5; r.res = 4'd6;  end
        else if (m <= 7'd50)  begin r.cp = 4'd3; r.res = 4'd12; end
        else if (m <= 7'd82)  begin r.cp = 4'd3; r.res = 4'd2;  end
        else if (m <= 7'd102) begin r.cp = 4'd4; r.res = 4'd2;  end
        else if (m <= 7'd106) begin r.cp = 4'd5; r.res = 4'd2;  end
        else                  begin r.cp = 4'd3; r.res = 4'd4;  end
        return r;
    endfunction

endpackage

// File: rtl/pll_seq_divider.sv
module pll_seq_divider #(
    parameter int unsigned W = 33
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         go,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         valid,
    output logic [W-1:0] quotient
);
    localparam int unsigned CW = $clog2(W + 1);

    logic [CW-1:0] steps;
    logic [W-1:0]  rem_q;
    logic [W-1:0]  quo_q;
    logic [W-1:0]  dvd_q;
    logic [W-1:0]  dvs_q;
    logic [W:0]    trial;
    logic          fits;
    logic [W:0]    rem_nxt;

    always_comb begin
        trial   = {rem_q, quo_q[W-1]};
        fits    = trial >= {1'b0, dvs_q};
        rem_nxt = fits ? (trial - {1'b0, dvs_q}) : trial;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            steps <= '0;
            rem_q <= '0;
            quo_q <= '0;
            dvd_q <= '0;
            dvs_q <= '0;
            valid <= 1'b0;
        end else begin
            valid <= 1'b0;
            if (go) begin
                quo_q <= dividend;
                dvd_q <= dividend;
                dvs_q <= divisor;
                rem_q <= '0;
                steps <= CW'(W);
            end else if (steps != '0) begin
                rem_q <= rem_nxt[W-1:0];
                quo_q <= {quo_q[W-2:0], fits};
                steps <= steps - 1'b1;
                if (steps == CW'(1)) valid <= 1'b1;
            end
        end
    end

    assign quotient = quo_q;

    logic [2*W-1:0] prod;
    logic [2*W-1:0] dvd_wide;
    logic [2*W-1:0] dvs_wide;
    always_comb begin
        dvd_wide = {{W{1'b0}}, dvd_q};
        dvs_wide = {{W{1'b0}}, dvs_q};
        prod     = {{W{1'b0}}, quo_q} * dvs_wide;
    end

    // R3: the quotient is the floor of dividend / divisor
    assert_floor_quotient_R3: assert property (@(posedge clk) disable iff (rst)
        valid |-> (prod <= dvd_wide) && ((dvd_wide - prod) < dvs_wide));

endmodule

// File: rtl/pll_seq_timer.sv
module pll_seq_timer #(
    parameter int unsigned LIMIT = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expired
);
    localparam int unsigned CW = (LIMIT < 2) ? 1 : $clog2(LIMIT);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) cnt <= '0;
        else if (!expired) cnt <= cnt + 1'b1;
    end

    assign expired = run && (cnt == CW'(LIMIT - 1));

endmodule

// File: rtl/pll_cfg_seq.sv
module pll_cfg_seq
    import pll_seq_pkg::*;
#(
    parameter int unsigned REF_HZ      = 33_333_000,
    parameter int unsigned FMIN_HZ     = 750_000_000,
    parameter int unsigned FMAX_HZ     = 1_600_000_000,
    parameter int unsigned VCO_MIN_HZ  = 1_500_000_000,
    parameter int unsigned RST_CYC     = 8,
    parameter int unsigned LOCK_TO_CYC = 25_000,
    parameter int unsigned FREQ_W      = 32,
    parameter int unsigned DATA_W      = 32
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic [FREQ_W-1:0]       target_hz,
    input  logic                    pll_locked,
    output logic                    wr_en,
    output logic                    wr_sel,
    output logic [DATA_W-1:0]       wr_data,
    output logic                    busy,
    output logic                    done,
    output logic                    err,
    output logic [MUL_W-1:0]        st_fdiv,
    output logic                    st_div2,
    output logic [3:0]              st_cp,
    output logic [3:0]              st_res,
    output logic [1:0]              st_lfhf,
    output logic [5:0]              st_lock_dly,
    output logic [9:0]              st_lock_cnt,
    output logic [FREQ_W+MUL_W-1:0] freq_hz
);
    localparam int unsigned QW = FREQ_W + 1;
    localparam int unsigned FW = FREQ_W + MUL_W;
    localparam logic [FREQ_W-1:0] FMIN = FREQ_W'(FMIN_HZ);
    localparam logic [FREQ_W-1:0] FMAX = FREQ_W'(FMAX_HZ);
    localparam logic [FREQ_W-1:0] VMIN = FREQ_W'(VCO_MIN_HZ);

    seq_state_e        state;
    logic [FREQ_W-1:0] tgt_q;
    logic [MUL_W-1:0]  mul_q;
    logic              div2_q;
    loop_cfg_t         cfg_q;

    logic              in_range;
    logic              want_div2;
    logic              div_go;
    logic [QW-1:0]     dividend;
    logic              div_valid;
    logic [QW-1:0]     quotient;
    logic [MUL_W-1:0]  mul_sat;
    logic              hold_run, hold_done;
    logic              lock_run, lock_expired;

    always_comb begin
        in_range  = (target_hz >= FMIN) && (target_hz <= FMAX);
        want_div2 = target_hz < VMIN;
        div_go    = (state == S_IDLE) && start && in_range;
        dividend  = want_div2 ? {target_hz, 1'b0} : {1'b0, target_hz};
        mul_sat   = (quotient > QW'(MUL_CAP)) ? MUL_CAP : quotient[MUL_W-1:0];
        hold_run  = (state == S_RST_HOLD);
        lock_run  = (state == S_LOCK_WAIT);
    end

    pll_seq_divider #(.W(QW)) u_div (
        .clk      (clk),
        .rst      (rst),
        .go       (div_go),
        .dividend (dividend),
        .divisor  (QW'(REF_HZ)),
        .valid    (div_valid),
        .quotient (quotient)
    );

    pll_seq_timer #(.LIMIT(RST_CYC)) u_hold (
        .clk     (clk),
        .rst     (rst),
        .run     (hold_run),
        .expired (hold_done)
    );

    pll_seq_timer #(.LIMIT(LOCK_TO_CYC)) u_lockwait (
        .clk     (clk),
        .rst     (rst),
        .run     (lock_run),
        .expired (lock_expired)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= S_IDLE;
            tgt_q   <= '0;
            mul_q   <= '0;
            div2_q  <= 1'b0;
            cfg_q   <= '0;
            wr_en   <= 1'b0;
            wr_sel  <= SEL_CTRL;
            wr_data <= '0;
            done    <= 1'b0;
            err     <= 1'b0;
        end else begin
            wr_en <= 1'b0;
            done  <= 1'b0;
            err   <= 1'b0;
            case (state)
                S_IDLE: if (start) begin
                    tgt_q  <= target_hz;
                    mul_q  <= '0;
                    div2_q <= 1'b0;
                    cfg_q  <= '0;
                    if (in_range) begin
                        div2_q <= want_div2;
                        state  <= S_DIVIDE;
                    end else begin
                        err <= 1'b1;
                    end
                end
                S_DIVIDE: if (div_valid) begin
                    mul_q <= mul_sat;
                    cfg_q <= lookup_loop(mul_sat);
                    state <= S_WR_MUL;
                end
                S_WR_MUL: begin
                    wr_en   <= 1'b1;
                    wr_sel  <= SEL_CTRL;
                    wr_data <= DATA_W'(make_ctrl(mul_q, div2_q, 1'b0, 1'b0));
                    state   <= S_WR_CFG;
                end
                S_WR_CFG: begin
                    wr_en   <= 1'b1;
                    wr_sel  <= SEL_CFG;
                    wr_data <= DATA_W'(cfg_q);
                    state   <= S_WR_BYP;
                end
                S_WR_BYP: begin
                    wr_en   <= 1'b1;
                    wr_sel  <= SEL_CTRL;
                    wr_data <= DATA_W'(make_ctrl(mul_q, div2_q, 1'b1, 1'b0));
                    state   <= S_WR_RST_ON;
                end
                S_WR_RST_ON: begin
                    wr_en   <= 1'b1;
                    wr_sel  <= SEL_CTRL;
                    wr_data <= DATA_W'(make_ctrl(mul_q, div2_q, 1'b1, 1'b1));
                    state   <= S_RST_HOLD;
                end
                S_RST_HOLD: if (hold_done) state <= S_WR_RST_OFF;
                S_WR_RST_OFF: begin
                    wr_en   <= 1'b1;
                    wr_sel  <= SEL_CTRL;
                    wr_data <= DATA_W'(make_ctrl(mul_q, div2_q, 1'b1, 1'b0));
                    state   <= S_LOCK_WAIT;
                end
                S_LOCK_WAIT: begin
                    if (pll_locked) begin
                        state <= S_WR_REL;
                    end else if (lock_expired) begin
                        err   <= 1'b1;
                        state <= S_IDLE;
                    end
                end
                S_WR_REL: begin
                    wr_en   <= 1'b1;
                    wr_sel  <= SEL_CTRL;
                    wr_data <= DATA_W'(make_ctrl(mul_q, div2_q, 1'b0, 1'b0));
                    state   <= S_FIN;
                end
                S_FIN: begin
                    done  <= 1'b1;
                    state <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assign busy        = (state != S_IDLE);
    assign st_fdiv     = mul_q;
    assign st_div2     = div2_q;
    assign st_cp       = cfg_q.cp;
    assign st_res      = cfg_q.res;
    assign st_lfhf     = cfg_q.lfhf;
    assign st_lock_dly = cfg_q.lock_dly;
    assign st_lock_cnt = cfg_q.lock_cnt;
    assign freq_hz     = FW'(mul_q) * FW'(REF_HZ);

    // Support logic for the reset-hold check: cycles since the reset-set strobe.
    logic [31:0] rst_age;
    logic        rst_seen;
    logic        rst_set_wr, rst_clr_wr;
    assign rst_set_wr = wr_en && (wr_sel == SEL_CTRL) && wr_data[CTRL_RST_BIT];
    assign rst_clr_wr = wr_en && (wr_sel == SEL_CTRL) && !wr_data[CTRL_RST_BIT]
                        && wr_data[CTRL_BYP_BIT] && rst_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            rst_age  <= '0;
            rst_seen <= 1'b0;
        end else if (rst_set_wr) begin
            rst_age  <= '0;
            rst_seen <= 1'b1;
        end else if (rst_clr_wr) begin
            rst_seen <= 1'b0;
        end else if (rst_seen && rst_age < 32'(RST_CYC)) begin
            rst_age <= rst_age + 32'd1;
        end
    end

    // R1: an out-of-range start is rejected in the next cycle with no write
    assert_reject_range_R1: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && ((target_hz < FMIN) || (target_hz > FMAX)))
        |=> (err && !busy && !wr_en));

    // R3: the reported multiplier never exceeds the cap
    assert_mul_cap_R3: assert property (@(posedge clk) disable iff (rst)
        st_fdiv <= MUL_CAP);

    // R7: the reset is held for at least RST_CYC cycles between the strobes
    assert_reset_hold_R7: assert property (@(posedge clk) disable iff (rst)
        rst_clr_wr |-> (rst_age + 32'd1 >= 32'(RST_CYC)));

    // R9: done follows directly on the bypass-release write
    assert_done_after_release_R9: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(wr_en && (wr_sel == SEL_CTRL) && !wr_data[CTRL_BYP_BIT]
                       && !wr_data[CTRL_RST_BIT]));

    // R9: done and err are exclusive
    assert_done_err_excl_R9: assert property (@(posedge clk) disable iff (rst)
        !(done && err));

    // R10: a start while busy leaves the accepted target untouched
    assert_busy_start_ignored_R10: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> $stable(tgt_q));

endmodule

// File: tb/sim_pll_cfg_seq.sv
`timescale 1ns/1ps
module sim_pll_cfg_seq;

    localparam int unsigned RST_CYC  = 4;
    localparam int unsigned LOCK_TO  = 100;
    localparam int          LOCK_LAT = 20;
    localparam longint      REF      = 33_333_000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] target_hz = '0;
    logic        pll_locked;
    logic        wr_en, wr_sel, busy, done, err, st_div2;
    logic [31:0] wr_data;
    logic [6:0]  st_fdiv;
    logic [3:0]  st_cp, st_res;
    logic [1:0]  st_lfhf;
    logic [5:0]  st_lock_dly;
    logic [9:0]  st_lock_cnt;
    logic [38:0] freq_hz;

    always #2 clk = ~clk;

    pll_cfg_seq #(.RST_CYC(RST_CYC), .LOCK_TO_CYC(LOCK_TO)) u0 (
        .clk(clk), .rst(rst), .start(start), .target_hz(target_hz),
        .pll_locked(pll_locked), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .busy(busy), .done(done), .err(err),
        .st_fdiv(st_fdiv), .st_div2(st_div2), .st_cp(st_cp), .st_res(st_res),
        .st_lfhf(st_lfhf), .st_lock_dly(st_lock_dly),
        .st_lock_cnt(st_lock_cnt), .freq_hz(freq_hz)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int last_wr_cyc = -10;
    int rst_on_cyc = -1;
    logic [32:0] exp_q[$];
    bit lock_en = 1'b1;
    bit in_rst;
    int lock_cd;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_sim();
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // PLL stand-in: lock drops on reset set, returns LOCK_LAT cycles after release
    always @(posedge clk) begin
        if (rst) begin
            pll_locked <= 1'b0;
            in_rst     <= 1'b0;
            lock_cd    <= 0;
        end else if (wr_en && !wr_sel && wr_data[9]) begin
            in_rst     <= 1'b1;
            pll_locked <= 1'b0;
            lock_cd    <= 0;
        end else if (wr_en && !wr_sel && in_rst) begin
            in_rst  <= 1'b0;
            lock_cd <= lock_en ? LOCK_LAT : 0;
        end else if (lock_cd > 1) begin
            lock_cd <= lock_cd - 1;
        end else if (lock_cd == 1) begin
            lock_cd    <= 0;
            pll_locked <= 1'b1;
        end
    end

    // Monitor: scoreboard of writes, reset hold and done timing
    always @(negedge clk) begin
        cyc++;
        if (!rst && wr_en) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R6", "unexpected write", longint'({wr_sel, wr_data}), -1);
            end else begin
                logic [32:0] e;
                e = exp_q.pop_front();
                check({wr_sel, wr_data} == e, "R5/R6", "write word",
                      longint'({wr_sel, wr_data}), longint'(e));
            end
            if (!wr_sel && wr_data[9]) rst_on_cyc = cyc;
            else if (!wr_sel && wr_data[8] && rst_on_cyc >= 0) begin
                check(cyc - rst_on_cyc >= RST_CYC, "R7", "reset hold",
                      cyc - rst_on_cyc, RST_CYC);
                rst_on_cyc = -1;
            end
            last_wr_cyc = cyc;
        end
        if (!rst && done)
            check(cyc == last_wr_cyc + 1, "R9", "done after release",
                  cyc - last_wr_cyc, 1);
        if (!rst && done && err)
            check(1'b0, "R9", "done with err", 1, 0);
    end

    task automatic exp_loop(input int d, output int cp, output int res, output int cnt);
        cnt = (d <= 37) ? 1000 : 600;
        if (d <= 26)       begin cp = 3; res = 10; end
        else if (d <= 30)  begin cp = 4; res = 6;  end
        else if (d <= 32)  begin cp = 6; res = 1;  end
        else if (d == 33)  begin cp = 4; res = 10; end
        else if (d <= 38)  begin cp = 5; res = 6;  end
        else if (d <= 50)  begin cp = 3; res = 12; end
        else if (d <= 82)  begin cp = 3; res = 2;  end
        else if (d <= 102) begin cp = 4; res = 2;  end
        else if (d <= 106) begin cp = 5; res = 2;  end
        else               begin cp = 3; res = 4;  end
        case (d)
            38: cnt = 975;  39: cnt = 950;  40: cnt = 925;  41: cnt = 900;
            42: cnt = 875;  43, 44: cnt = 850;  45: cnt = 825;  46: cnt = 800;
            47, 48: cnt = 775;  49, 50: cnt = 750;  51: cnt = 725;
            52, 53: cnt = 700;  54, 55: cnt = 675;  56, 57: cnt = 650;
            58, 59, 60: cnt = 625;
            default: ;
        endcase
    endtask

    task automatic run(input longint t, input bit lock_ok, input bit poke);
        bit ok_range;
        bit d2;
        int d, cp, res, cnt, n;
        logic [31:0] base, cfgw;
        ok_range = (t >= 750_000_000) && (t <= 1_600_000_000);
        d2 = (t < 1_500_000_000);
        d = int'((t * (d2 ? 2 : 1)) / REF);
        if (d > 125) d = 125;
        exp_loop(d, cp, res, cnt);
        base = 32'(d) | (32'(d2) << 7);
        cfgw = (32'(cnt) << 16) | (32'd63 << 10) | (32'd3 << 8) | (32'(res) << 4) | 32'(cp);
        if (ok_range) begin
            exp_q.push_back({1'b0, base});
            exp_q.push_back({1'b1, cfgw});
            exp_q.push_back({1'b0, base | 32'h100});
            exp_q.push_back({1'b0, base | 32'h300});
            exp_q.push_back({1'b0, base | 32'h100});
            if (lock_ok) exp_q.push_back({1'b0, base});
        end
        lock_en = lock_ok;
        @(negedge clk);
        start = 1'b1;
        target_hz = 32'(t);
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (10) @(negedge clk);
            check(busy == 1'b1, "R10", "busy at second start", busy, 1);
            start = 1'b1;
            target_hz = 32'd800_000_000;
            @(negedge clk);
            start = 1'b0;
        end
        n = 0;
        while (!done && !err && n < 2000) begin
            @(negedge clk);
            n++;
        end
        if (!ok_range) begin
            check(err == 1'b1 && n == 0, "R1", "reject err next cycle", n, 0);
            check(st_fdiv == 0 && st_cp == 0, "R1", "status cleared", st_fdiv, 0);
        end else if (!lock_ok) begin
            check(err == 1'b1 && done == 1'b0, "R8", "lock timeout err", err, 1);
        end else begin
            check(done == 1'b1 && err == 1'b0, poke ? "R10" : "R6", "done", done, 1);
        end
        if (ok_range) begin
            check(st_div2 == d2, "R2", "div2", st_div2, d2);
            check(st_fdiv == d, "R3", "multiplier", st_fdiv, d);
            check(st_cp == cp, "R4", "charge pump", st_cp, cp);
            check(st_res == res, "R4", "resistor", st_res, res);
            check(st_lock_cnt == cnt, "R4", "lock count", st_lock_cnt, cnt);
            check(st_lfhf == 3 && st_lock_dly == 63, "R4", "fixed fields",
                  st_lock_dly, 63);
            check(freq_hz == longint'(d) * REF, "R11", "freq_hz",
                  longint'(freq_hz), longint'(d) * REF);
        end
        repeat (LOCK_LAT + 5) @(negedge clk);
        check(exp_q.size() == 0, lock_ok ? "R6" : "R8", "writes outstanding",
              exp_q.size(), 0);
        exp_q.delete();
        check(busy == 1'b0, "R8", "idle after run", busy, 0);
        if (ok_range)
            check(st_fdiv == d, "R11", "status held", st_fdiv, d);
    endtask

    initial begin
        #(4 * 150_000);
        check(1'b0, "WDOG", "watchdog expired", 0, 1);
        finish_sim();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !done && !err && !wr_en, "R9", "reset idle outputs",
              {busy, done, err, wr_en}, 0);
        check(st_fdiv == 0 && freq_hz == 0, "R11", "reset status", st_fdiv, 0);
        run(1_000_000_000, 1, 0);
        run(1_600_000_000, 1, 0);
        run(750_000_000,   1, 0);
        run(1_500_000_000, 1, 0);
        run(1_499_999_999, 1, 0);
        run(1_300_000_000, 1, 0);
        run(1_400_000_000, 1, 1);
        run(749_999_999,   1, 0);
        run(1_600_000_001, 1, 0);
        run(1_200_000_000, 0, 0);
        run(1_550_000_000, 1, 0);
        finish_sim();
    end

endmodule